// File: doc/BRIEF.md
# Sign-Steered Windowed Correlator Accumulator

This block sums a stream of small signed samples over a fixed window of valid samples and emits one result per window. Each sample arrives as a sign bit and a magnitude. The sample is not sign-extended into one wide adder. Its magnitude goes to one of two unsigned accumulators, and the sign bit picks which one. The other accumulator keeps its clock enable low, so its bits do not toggle. A run of samples that keeps changing sign therefore switches far fewer bits than a single accumulator would.

Each magnitude accumulator has two parts. A narrow adder covers the low bits. The high bits sit on an incrementer that moves only on a carry out of the low part. At the end of a window the block registers the positive total minus the negative total as a signed result and pulses a valid flag for one cycle. Both accumulators clear on that same edge, so the next window starts from zero with no idle cycle.

A parameter selects a conventional single two's complement accumulator instead. This mode gives the same results with the same timing and serves as a functional comparison point.

Top module: `sacc_top`

## Requirements
- R1: While reset is asserted and after it is released, `res_valid_o` is 0 and `res_data_o` is 0 until the first window completes.
- R2: `res_valid_o` is high for exactly one cycle, in the cycle after the edge that accepts the WIN_LEN-th valid sample of a window. Cycles with `in_valid_i` low do not count toward the window.
- R3: `res_data_o` equals the sum of the positive sample magnitudes minus the sum of the negative sample magnitudes over the WIN_LEN valid samples of the window, and this sum includes the last sample.
- R4: Sample encoding: bit MAG_W (bit 3 by default) is the sign, where 1 means negative. Bits MAG_W-1:0 are the magnitude. A sample with sign 1 and magnitude 0 counts as zero.
- R5: Both accumulators clear on the edge that closes a window. The result of each window depends only on that window's samples.
- R6: An accumulator changes only when a valid sample with a nonzero magnitude and the matching sign arrives, or when a window closes. Invalid cycles and zero-magnitude samples leave both accumulators unchanged.
- R7: Full-scale windows are exact: WIN_LEN samples of magnitude 7 give +7168 or -7168 with default parameters, and no accumulator wraps.
- R8: In the two's complement mode, `res_valid_o` and `res_data_o` are identical, cycle for cycle, to those of the sign-steered mode for the same input.
- R9: `res_data_o` holds its value between result pulses.
- R10: The high part of a magnitude accumulator changes only when the low-part adder produces a carry out, or when the accumulator is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Sample valid |
| smp_i | input | MAG_W+1 | Sample: sign in the MSB, magnitude below it |
| res_valid_o | output | 1 | One-cycle pulse at the end of each window |
| res_data_o | output | ACC_W+1 | Signed window result |

## Verification
The following are checked on every cycle by assertions:
- the window counter stays in range and wraps after the last sample;
- an accumulator stays unchanged when its enable is low;
- the high part moves only on a low-part carry;
- neither accumulator wraps;
- both accumulators are zero after a window closes;
- the result pulse lasts one cycle, and the result holds while no sample arrives.

The arithmetic of the result can only be shown by the bench's scenarios. These cover:
- sweeps over all sixteen sample codes with invalid gaps;
- full-scale positive and negative windows;
- fast sign alternation;
- negative zero;
- pseudo-random windows.

In every scenario both modes are compared against a sum computed in the bench.

// File: rtl/sacc_pkg.sv
`timescale 1ns/1ps
package sacc_pkg;

  typedef enum logic {
    ARCH_SIGNMAG = 1'b0,
    ARCH_TWOS    = 1'b1
  } sacc_arch_e;

  // Bits needed to hold WIN samples of full-scale magnitude without wrapping.
  function automatic int unsigned acc_width(input int unsigned mag_w,
                                            input int unsigned win);
    longint unsigned peak;
    peak = ((longint'(1) << mag_w) - 1) * longint'(win) + 1;
    return $clog2(peak);
  endfunction

endpackage

// File: rtl/sacc_window_ctr.sv
`timescale 1ns/1ps
module sacc_window_ctr #(
  parameter int unsigned WIN_LEN = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  output logic last_o
);
  localparam int unsigned CNT_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIN_LEN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    last_o = step_i && (cnt_q == CNT_LAST);
    cnt_en = step_i;
    cnt_d  = last_o ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R2: counter never leaves the window range
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);

  // R2: after the last sample the count restarts at zero
  a_r2_cnt_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> (cnt_q == '0));

endmodule

// File: rtl/sacc_mag_acc.sv
`timescale 1ns/1ps
module sacc_mag_acc #(
  parameter int unsigned MAG_W = 3,
  parameter int unsigned ACC_W = 13,
  parameter int unsigned LO_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [MAG_W-1:0] mag_i,
  output logic [ACC_W-1:0] nxt_o
);
  localparam int unsigned HI_W = ACC_W - LO_W;

  logic [LO_W-1:0] lo_q, lo_d;
  logic [HI_W-1:0] hi_q, hi_d;
  logic [LO_W:0]   lo_sum;
  logic            carry;
  logic [HI_W-1:0] hi_inc;
  logic            lo_ce, hi_ce;

  // narrow adder on the low bits, incrementer on the high bits
  always_comb begin
    lo_sum = {1'b0, lo_q} + (LO_W+1)'(mag_i);
    carry  = en_i & lo_sum[LO_W];
    hi_inc = hi_q + HI_W'(1);
    nxt_o  = en_i ? {(carry ? hi_inc : hi_q), lo_sum[LO_W-1:0]} : {hi_q, lo_q};
  end

  // written-out clock enables: the high part only clocks on a carry
  always_comb begin
    lo_ce = clr_i | en_i;
    hi_ce = clr_i | carry;
    lo_d  = clr_i ? '0 : lo_sum[LO_W-1:0];
    hi_d  = clr_i ? '0 : hi_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (lo_ce) lo_q <= lo_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (hi_ce) hi_q <= hi_d;
  end

  // R6: an unselected accumulator does not move
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> ($stable(lo_q) && $stable(hi_q)));

  // R10: the high part moves only on a low-part carry
  a_r10_hi_carry_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !(en_i && lo_sum[LO_W])) |=> $stable(hi_q));

  // R7: the accumulator never wraps
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> !(lo_sum[LO_W] && (&hi_q)));

  // R5: the window close leaves the accumulator empty
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (lo_q == '0 && hi_q == '0));

endmodule

// File: rtl/sacc_twos_acc.sv
`timescale 1ns/1ps
module sacc_twos_acc #(
  parameter int unsigned MAG_W = 3,
  parameter int unsigned RES_W = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_i,
  input  logic                    clr_i,
  input  logic                    neg_i,
  input  logic [MAG_W-1:0]        mag_i,
  output logic signed [RES_W-1:0] nxt_o
);
  logic signed [RES_W-1:0] acc_q, acc_d, addend;
  logic                    acc_ce;

  always_comb begin
    addend = neg_i ? -$signed(RES_W'(mag_i)) : $signed(RES_W'(mag_i));
    nxt_o  = en_i ? acc_q + addend : acc_q;
    acc_ce = en_i | clr_i;
    acc_d  = clr_i ? '0 : nxt_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_ce) acc_q <= acc_d;
  end

  // R6: invalid cycles leave the accumulator unchanged
  a_r6_twos_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> $stable(acc_q));

  // R5: cleared at window close
  a_r5_twos_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (acc_q == '0));

endmodule

// File: rtl/sacc_top.sv
`timescale 1ns/1ps
module sacc_top #(
  parameter int unsigned          MAG_W   = 3,
  parameter int unsigned          WIN_LEN = 1024,
  parameter int unsigned          LO_W    = 4,
  parameter sacc_pkg::sacc_arch_e ARCH    = sacc_pkg::ARCH_SIGNMAG,
  localparam int unsigned         ACC_W   = sacc_pkg::acc_width(MAG_W, WIN_LEN),
  localparam int unsigned         RES_W   = ACC_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid_i,
  input  logic [MAG_W:0]          smp_i,
  output logic                    res_valid_o,
  output logic signed [RES_W-1:0] res_data_o
);
  logic             smp_neg;
  logic [MAG_W-1:0] smp_mag;
  logic             smp_nz;
  logic             win_last;
  logic signed [RES_W-1:0] result_d;
  logic                    res_valid_q;
  logic signed [RES_W-1:0] res_data_q;

  always_comb begin
    smp_neg = smp_i[MAG_W];
    smp_mag = smp_i[MAG_W-1:0];
    smp_nz  = |smp_mag;
  end

  sacc_window_ctr #(.WIN_LEN(WIN_LEN)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (in_valid_i),
    .last_o (win_last)
  );

  generate
    if (ARCH == sacc_pkg::ARCH_SIGNMAG) begin : g_signmag
      logic             pos_en, neg_en;
      logic [ACC_W-1:0] pos_nxt, neg_nxt;

      always_comb begin
        pos_en = in_valid_i & smp_nz & ~smp_neg;
        neg_en = in_valid_i & smp_nz &  smp_neg;
      end

      sacc_mag_acc #(.MAG_W(MAG_W), .ACC_W(ACC_W), .LO_W(LO_W)) u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (pos_en),
        .clr_i (win_last),
        .mag_i (smp_mag),
        .nxt_o (pos_nxt)
      );

      sacc_mag_acc #(.MAG_W(MAG_W), .ACC_W(ACC_W), .LO_W(LO_W)) u_neg (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (neg_en),
        .clr_i (win_last),
        .mag_i (smp_mag),
        .nxt_o (neg_nxt)
      );

      always_comb result_d = $signed({1'b0, pos_nxt}) - $signed({1'b0, neg_nxt});

      // R6: at most one magnitude accumulator accepts a sample, and only a valid one
      a_r6_steer: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_en || neg_en) |-> (in_valid_i && smp_nz));
    end else begin : g_twos
      sacc_twos_acc #(.MAG_W(MAG_W), .RES_W(RES_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (in_valid_i),
        .clr_i (win_last),
        .neg_i (smp_neg),
        .mag_i (smp_mag),
        .nxt_o (result_d)
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_valid_q <= 1'b0;
    else        res_valid_q <= win_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        res_data_q <= '0;
    else if (win_last) res_data_q <= result_d;
  end

  assign res_valid_o = res_valid_q;
  assign res_data_o  = res_data_q;

  // R2: a result pulse lasts exactly one cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |=> !res_valid_o);

  // R9: without an accepted sample, no pulse follows and the result holds
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> (!res_valid_o && $stable(res_data_o)));

endmodule

// File: tb/sacc_top_test.sv
`timescale 1ns/1ps
module sacc_top_test;
  localparam int WIN = 1024;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [3:0] smp;
  logic res_valid, res_valid_tc;
  logic signed [13:0] res_data, res_data_tc;

  int checks = 0;
  int errors = 0;
  int cnt = 0;
  int sum = 0;
  int last_res = 0;
  bit done = 0;
  int unsigned lfsr = 32'h1234_5678;

  always #4 clk = ~clk;

  sacc_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .smp_i(smp),
    .res_valid_o(res_valid), .res_data_o(res_data));

  sacc_top #(.ARCH(sacc_pkg::ARCH_TWOS)) uut_tc (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .smp_i(smp),
    .res_valid_o(res_valid_tc), .res_data_o(res_data_tc));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive one cycle at the falling edge, check just after the rising edge
  task automatic step(input bit v, input logic [3:0] s, input string req);
    bit pulse;
    @(negedge clk);
    in_valid = v;
    smp = s;
    pulse = 0;
    if (v) begin
      sum += s[3] ? -int'(s[2:0]) : int'(s[2:0]);   // R4 encoding
      cnt++;
      if (cnt == WIN) begin
        pulse = 1;
        last_res = sum;
        sum = 0;          // R5: next window starts from zero
        cnt = 0;
      end
    end
    @(posedge clk);
    #2;
    if (pulse) begin
      check({"R2 pulse ", req}, int'(res_valid), 1);
      check({"R3 result ", req}, int'(res_data), last_res);
      check({"R8 twos result ", req}, int'(res_data_tc), last_res);
    end else if (res_valid || res_valid_tc || int'(res_data) != last_res
                 || int'(res_data_tc) != last_res) begin
      check({"R9 idle hold ", req}, int'(res_data), last_res);
      check({"R2 no pulse ", req}, int'(res_valid) + int'(res_valid_tc), 0);
    end
  endtask

  function automatic logic [3:0] rnd4();
    lfsr = lfsr * 32'd1664525 + 32'd1013904223;
    return lfsr[27:24];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; smp = '0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset valid", int'(res_valid), 0);
    check("R1 reset data", int'(res_data), 0);
    @(negedge clk); rst_n = 1'b1;
    step(0, 4'h0, "R1 idle");
    check("R1 after release", int'(res_data) + int'(res_valid), 0);

    // R2 R4: sweep all sixteen codes, invalid gaps do not count
    for (int i = 0; i < 1300; i++) begin
      step(1, 4'(i % 16), "sweep");
      if (i % 5 == 0) step(0, 4'(15 - i % 16), "R6 gap");
    end
    // R2: finish the partial window and probe alignment
    while (cnt != 0) step(1, 4'(cnt % 13), "R2 align");

    // R7: full-scale positive then negative
    for (int i = 0; i < WIN; i++) step(1, 4'h7, "R7 full pos");
    check("R7 pos peak", last_res, 7168);
    for (int i = 0; i < WIN; i++) step(1, 4'hF, "R7 full neg");
    check("R7 neg peak", last_res, -7168);

    // R6: fast sign alternation
    for (int i = 0; i < WIN; i++) step(1, (i % 2) ? 4'hF : 4'h7, "R6 alternate");

    // R4: negative zero counts as zero, mixed with +1
    for (int i = 0; i < WIN; i++) step(1, (i % 4 == 0) ? 4'h1 : 4'h8, "R4 neg zero");
    check("R4 neg zero sum", last_res, 256);

    // R3 R8: pseudo-random windows with random gaps
    for (int w = 0; w < 3 * WIN; w++) begin
      logic [3:0] r;
      r = rnd4();
      step(r[0] | r[1], rnd4(), "R3 random");
    end
    while (cnt != 0) step(1, rnd4(), "R3 random tail");

    // R9: long idle keeps the last result
    for (int i = 0; i < 20; i++) step(0, rnd4(), "R9 idle");
    check("R9 final hold", int'(res_data), last_res);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule